// File: doc/BRIEF.md
# I2C Start and Repeated-Start Request Controller

This block turns a software request for a start condition into the line activity that opens an I2C transfer. It watches the two bus lines to learn whether the bus is occupied. It decides what each start request means from the bus state and from this device's own role. It then drives the open-drain SDA and SCL pull-downs to form a start condition or a repeated start. The byte shifter, the acknowledge logic and the stop generator sit beside it. Only their status signals (master wait, acknowledge period, arbitration lost) come into this block.

A request on a free bus starts at once. If another master holds the bus, the request is either parked as a reservation that fires by itself when the bus is released, or refused with a sticky flag. A configuration input selects which. A request made while this device is master and stalled in its wait period becomes a repeated start. That repeated start begins only after the wait ends. The setup and hold times of the generated conditions are set in clock cycles at run time.

Top module: `i2c_start_ctrl`

## Requirements
- R1: With `enable` high, the bus free, not in the acknowledge period and `stop_req` low, a `start_req` pulse sets `pending` on the next edge. `sda_low` asserts one cycle later while `scl_low` stays low. After `hold_cyc` cycles (minimum 1), `scl_low` asserts, `pending` clears and `is_master` sets. `scl_low` never rises unless `sda_low` is already high.
- R2: A start request made while `bus_busy` is high, this device is not master and `resv_off` is 0 is held in `pending` without driving the lines. On the edge where the bus monitor sees the release, `bus_busy` clears, and `sda_low` asserts one cycle after that.
- R3: A start request made while `bus_busy` is high, this device is not master and `resv_off` is 1 leaves `pending` low, drives nothing and sets `start_rejected` on the next edge.
- R4: `start_rejected` and `req_conflict` stay set until a `flag_clr` pulse clears both.
- R5: A start request made while `is_master` and `master_wait` are high sets `pending` but does not act while `master_wait` stays high. On the first edge with `master_wait` low, the repeated start begins. SDA is released with SCL held low for `rel_cyc` cycles. Then both lines are released for `rel_cyc` cycles. Then SDA is pulled low for `hold_cyc` cycles. Then both lines are held low.
- R6: `arb_lost` or `exit_req` clears `pending` on the next edge, abandons any condition in progress and releases both lines.
- R7: While `enable` is 0, start requests are ignored, `pending` is 0, both pull-downs are off and `bus_busy` is 0.
- R8: `start_req` and `stop_req` high in the same cycle are both ignored, and `req_conflict` is set.
- R9: A start request made while `ack_phase` is high is ignored, and no flag is set.
- R10: `bus_busy` sets on the edge after SDA falls while SCL is high, and clears on the edge after SDA rises while SCL is high. SDA changing while SCL is low leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; 0 stops and clears everything |
| resv_off | input | 1 | 1 = refuse starts on a busy bus, 0 = reserve them |
| start_req | input | 1 | One-cycle start request strobe |
| stop_req | input | 1 | One-cycle stop request strobe (observed for conflict only) |
| exit_req | input | 1 | One-cycle strobe to leave communication |
| flag_clr | input | 1 | One-cycle strobe clearing the sticky flags |
| master_wait | input | 1 | This master is stalled after the ninth clock |
| ack_phase | input | 1 | Acknowledge bit period in progress |
| arb_lost | input | 1 | Arbitration lost pulse |
| hold_cyc | input | TW | Cycles SDA is low before SCL is pulled low |
| rel_cyc | input | TW | Cycles for each release step of a repeated start |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_low | output | 1 | Pull SCL low |
| sda_low | output | 1 | Pull SDA low |
| bus_busy | output | 1 | Bus occupied by some master |
| is_master | output | 1 | This device owns the bus |
| pending | output | 1 | A start or repeated start is waiting to be issued |
| start_rejected | output | 1 | Sticky: a start was refused on a busy bus |
| req_conflict | output | 1 | Sticky: start and stop were requested together |

## Verification
A reserved request can meet the release of the bus in the very cycle the bus monitor sees SDA rise with SCL high. Busy-flag clearing and automatic start launch therefore both depend on one edge. The bench holds a reservation, drives that rising SDA edge from the other master's side, and requires `bus_busy` low with the lines still free after that edge. It then requires `sda_low` high exactly one edge later. The second collision is a start and a stop strobe in one cycle. The bench provokes it on both a free and a busy bus and judges it by `pending` staying low, `req_conflict` setting and `start_rejected` staying clear.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int unsigned DEF_TW = 8;

  typedef enum logic [1:0] {
    GEN_IDLE = 2'd0,
    GEN_RSDA = 2'd1,
    GEN_RSCL = 2'd2,
    GEN_HOLD = 2'd3
  } gen_st_e;
endpackage

// File: rtl/i2cs_bus_mon.sv
module i2cs_bus_mon (
  input  logic clk,
  input  logic rst_sn,
  input  logic enable,
  input  logic scl_in,
  input  logic sda_in,
  output logic busy,
  output logic stop_seen
);
  logic scl_q, sda_q;
  logic busy_n;
  logic start_seen;

  // conditions are judged on two consecutive samples with SCL high in both
  always_comb begin
    start_seen = scl_q & scl_in & sda_q & ~sda_in;
    stop_seen  = scl_q & scl_in & ~sda_q & sda_in;
    busy_n     = busy;
    if (!enable)         busy_n = 1'b0;
    else if (start_seen) busy_n = 1'b1;
    else if (stop_seen)  busy_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      busy  <= 1'b0;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
      busy  <= busy_n;
    end
  end
endmodule

// File: rtl/i2cs_req_ctrl.sv
module i2cs_req_ctrl (
  input  logic clk,
  input  logic rst_sn,
  input  logic enable,
  input  logic resv_off,
  input  logic start_req,
  input  logic stop_req,
  input  logic exit_req,
  input  logic flag_clr,
  input  logic master_wait,
  input  logic ack_phase,
  input  logic arb_lost,
  input  logic busy,
  input  logic stop_seen,
  input  logic gen_idle,
  input  logic gen_done,
  output logic launch,
  output logic launch_rs,
  output logic pending,
  output logic is_master,
  output logic rejected,
  output logic conflict
);
  logic pend_n, kind_rs, kind_rs_n, master_n, rej_n, conf_n;
  logic req_ok, req_clash, clear_pend;
  logic take_rs, take_st, refuse;

  always_comb begin
    req_ok     = enable & start_req & ~stop_req & ~ack_phase;
    req_clash  = enable & start_req & stop_req;
    clear_pend = ~enable | arb_lost | exit_req | gen_done;

    // repeated start only from the wait period of an owned transfer
    take_rs = req_ok & is_master & master_wait;
    // fresh start on a free bus, or a reservation on a busy one
    take_st = req_ok & ~is_master & (~busy | ~resv_off);
    refuse  = req_ok & ~is_master & busy & resv_off;

    pend_n    = pending;
    kind_rs_n = kind_rs;
    if (clear_pend) begin
      pend_n = 1'b0;
    end else if (!pending && (take_rs || take_st)) begin
      pend_n    = 1'b1;
      kind_rs_n = take_rs;
    end

    master_n = is_master;
    if (~enable | arb_lost | exit_req | stop_seen) master_n = 1'b0;
    else if (gen_done)                             master_n = 1'b1;

    rej_n  = flag_clr ? 1'b0 : (rejected | refuse);
    conf_n = flag_clr ? 1'b0 : (conflict | req_clash);

    launch_rs = kind_rs;
    launch    = pending & gen_idle & ~clear_pend &
                (kind_rs ? (is_master & ~master_wait) : ~busy);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      pending   <= 1'b0;
      kind_rs   <= 1'b0;
      is_master <= 1'b0;
      rejected  <= 1'b0;
      conflict  <= 1'b0;
    end else begin
      pending   <= pend_n;
      kind_rs   <= kind_rs_n;
      is_master <= master_n;
      rejected  <= rej_n;
      conflict  <= conf_n;
    end
  end
endmodule

// File: rtl/i2cs_cond_gen.sv
module i2cs_cond_gen
  import i2cs_pkg::*;
#(
  parameter int unsigned TW = DEF_TW
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          launch,
  input  logic          launch_rs,
  input  logic          abort,
  input  logic [TW-1:0] hold_cyc,
  input  logic [TW-1:0] rel_cyc,
  output logic          sda_low,
  output logic          scl_low,
  output logic          idle,
  output logic          done
);
  localparam int unsigned CW = TW + 1;

  gen_st_e       st, st_n;
  logic [TW-1:0] cnt, cnt_n;
  logic          park, park_n;
  logic          hold_last, rel_last;

  always_comb begin
    // a zero length behaves as one cycle
    hold_last = ({1'b0, cnt} + CW'(1)) >= {1'b0, hold_cyc};
    rel_last  = ({1'b0, cnt} + CW'(1)) >= {1'b0, rel_cyc};
    st_n   = st;
    cnt_n  = cnt;
    park_n = park;
    done   = 1'b0;
    if (abort) begin
      st_n   = GEN_IDLE;
      park_n = 1'b0;
      cnt_n  = '0;
    end else begin
      unique case (st)
        GEN_IDLE: if (launch) begin
          cnt_n = '0;
          st_n  = launch_rs ? GEN_RSDA : GEN_HOLD;
        end
        GEN_RSDA: if (rel_last) begin
          cnt_n = '0;
          st_n  = GEN_RSCL;
        end else cnt_n = cnt + TW'(1);
        GEN_RSCL: if (rel_last) begin
          cnt_n = '0;
          st_n  = GEN_HOLD;
        end else cnt_n = cnt + TW'(1);
        GEN_HOLD: if (hold_last) begin
          st_n   = GEN_IDLE;
          park_n = 1'b1;
          done   = 1'b1;
        end else cnt_n = cnt + TW'(1);
        default: st_n = GEN_IDLE;
      endcase
    end
    sda_low = (st == GEN_HOLD) | ((st == GEN_IDLE) & park);
    scl_low = (st == GEN_RSDA) | ((st == GEN_IDLE) & park);
    idle    = (st == GEN_IDLE);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st   <= GEN_IDLE;
      cnt  <= '0;
      park <= 1'b0;
    end else begin
      st   <= st_n;
      cnt  <= cnt_n;
      park <= park_n;
    end
  end
endmodule

// File: rtl/i2c_start_ctrl.sv
module i2c_start_ctrl
  import i2cs_pkg::*;
#(
  parameter int unsigned TW = DEF_TW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          resv_off,
  input  logic          start_req,
  input  logic          stop_req,
  input  logic          exit_req,
  input  logic          flag_clr,
  input  logic          master_wait,
  input  logic          ack_phase,
  input  logic          arb_lost,
  input  logic [TW-1:0] hold_cyc,
  input  logic [TW-1:0] rel_cyc,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_low,
  output logic          sda_low,
  output logic          bus_busy,
  output logic          is_master,
  output logic          pending,
  output logic          start_rejected,
  output logic          req_conflict
);
  logic [1:0] rst_pipe;
  logic       rst_sn;
  logic       stop_seen, gen_idle, gen_done, launch, launch_rs, abort;

  // reset asserts at once and leaves on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];
  assign abort  = ~enable | arb_lost | exit_req;

  i2cs_bus_mon u_mon (
    .clk(clk), .rst_sn(rst_sn), .enable(enable),
    .scl_in(scl_in), .sda_in(sda_in),
    .busy(bus_busy), .stop_seen(stop_seen)
  );

  i2cs_req_ctrl u_req (
    .clk(clk), .rst_sn(rst_sn), .enable(enable), .resv_off(resv_off),
    .start_req(start_req), .stop_req(stop_req), .exit_req(exit_req),
    .flag_clr(flag_clr), .master_wait(master_wait), .ack_phase(ack_phase),
    .arb_lost(arb_lost), .busy(bus_busy), .stop_seen(stop_seen),
    .gen_idle(gen_idle), .gen_done(gen_done), .launch(launch),
    .launch_rs(launch_rs), .pending(pending), .is_master(is_master),
    .rejected(start_rejected), .conflict(req_conflict)
  );

  i2cs_cond_gen #(.TW(TW)) u_gen (
    .clk(clk), .rst_sn(rst_sn), .launch(launch), .launch_rs(launch_rs),
    .abort(abort), .hold_cyc(hold_cyc), .rel_cyc(rel_cyc),
    .sda_low(sda_low), .scl_low(scl_low), .idle(gen_idle), .done(gen_done)
  );
endmodule

// File: rtl/i2c_start_ctrl_chk.sv
module i2c_start_ctrl_chk (
  input logic clk,
  input logic rst_sn,
  input logic enable,
  input logic resv_off,
  input logic start_req,
  input logic stop_req,
  input logic exit_req,
  input logic flag_clr,
  input logic ack_phase,
  input logic arb_lost,
  input logic scl_in,
  input logic sda_in,
  input logic scl_low,
  input logic sda_low,
  input logic bus_busy,
  input logic is_master,
  input logic pending,
  input logic start_rejected,
  input logic req_conflict
);
  // R1
  sda_before_scl_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(scl_low) |-> sda_low);

  // R3
  refuse_busy_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (enable && start_req && !stop_req && !ack_phase && bus_busy && !is_master
     && resv_off && !pending && !exit_req && !arb_lost)
    |=> (!pending && start_rejected));

  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    ((start_rejected || req_conflict) && !flag_clr)
    |=> (start_rejected || req_conflict));

  // R6
  drop_on_loss_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (arb_lost || exit_req) |=> (!pending && !sda_low && !scl_low));

  // R7
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !enable |=> (!pending && !sda_low && !scl_low && !bus_busy));

  // R8
  clash_flag_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (enable && start_req && stop_req && !pending) |=> (!pending && req_conflict));

  // R9
  ack_ignore_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (enable && start_req && ack_phase && !pending) |=> !pending);

  // R10
  busy_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (enable && scl_in && $past(scl_in) && $past(sda_in) && !sda_in) |=> bus_busy);
endmodule

bind i2c_start_ctrl i2c_start_ctrl_chk u_chk (.*);

// File: tb/i2c_start_ctrl_bench.sv
`timescale 1ns/1ps
module i2c_start_ctrl_bench;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic enable, resv_off, start_req, stop_req, exit_req, flag_clr;
  logic master_wait, ack_phase, arb_lost;
  logic [TW-1:0] hold_cyc, rel_cyc;
  logic ext_scl, ext_sda;
  logic scl_in, sda_in;
  logic scl_low, sda_low, bus_busy, is_master, pending, start_rejected, req_conflict;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign scl_in = ext_scl & ~scl_low;
  assign sda_in = ext_sda & ~sda_low;

  i2c_start_ctrl #(.TW(TW)) u_i2c_start_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .resv_off(resv_off),
    .start_req(start_req), .stop_req(stop_req), .exit_req(exit_req),
    .flag_clr(flag_clr), .master_wait(master_wait), .ack_phase(ack_phase),
    .arb_lost(arb_lost), .hold_cyc(hold_cyc), .rel_cyc(rel_cyc),
    .scl_in(scl_in), .sda_in(sda_in), .scl_low(scl_low), .sda_low(sda_low),
    .bus_busy(bus_busy), .is_master(is_master), .pending(pending),
    .start_rejected(start_rejected), .req_conflict(req_conflict)
  );

  // fields: en ro busy ack start stop | pend rej conf
  localparam logic [8:0] VEC [11] = '{
    9'b100010_100, 9'b101010_100, 9'b111010_010, 9'b110010_100,
    9'b000010_000, 9'b011010_000, 9'b100011_001, 9'b111011_001,
    9'b100110_000, 9'b111110_000, 9'b101001_000
  };

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    start_req = 1'b1; tick(); start_req = 1'b0;
  endtask

  task automatic clean();
    exit_req = 1'b1; flag_clr = 1'b1; tick();
    exit_req = 1'b0; flag_clr = 1'b0;
    ext_sda = 1'b1; ext_scl = 1'b1; resv_off = 1'b0; ack_phase = 1'b0;
    master_wait = 1'b0; enable = 1'b0; tick();
    enable = 1'b1; tick(2);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    string tag;
    rst_n = 1'b0; enable = 1'b0; resv_off = 1'b0; start_req = 1'b0;
    stop_req = 1'b0; exit_req = 1'b0; flag_clr = 1'b0; master_wait = 1'b0;
    ack_phase = 1'b0; arb_lost = 1'b0; hold_cyc = 8'd4; rel_cyc = 8'd3;
    ext_scl = 1'b1; ext_sda = 1'b1;
    tick(3); rst_n = 1'b1; tick(4);

    // reset state (R7 idle values)
    chk("R7", "reset pending", pending, 1'b0);
    chk("R7", "reset sda_low", sda_low, 1'b0);
    chk("R7", "reset scl_low", scl_low, 1'b0);
    chk("R4", "reset rejected", start_rejected, 1'b0);
    chk("R1", "reset is_master", is_master, 1'b0);

    // decision table
    for (int v = 0; v < 11; v++) begin
      logic [8:0] e;
      e = VEC[v];
      clean();
      enable = e[8]; resv_off = e[7]; ack_phase = e[5];
      tick();
      if (e[6]) begin ext_sda = 1'b0; tick(2); end
      if (e[4] && e[3])      tag = "R8";
      else if (!e[8])        tag = "R7";
      else if (e[5])         tag = "R9";
      else if (e[6] && e[7]) tag = "R3";
      else if (e[6])         tag = "R2";
      else                   tag = "R1";
      start_req = e[4]; stop_req = e[3]; tick();
      start_req = 1'b0; stop_req = 1'b0;
      chk(tag, "table pending", pending, e[2]);
      chk(tag, "table rejected", start_rejected, e[1]);
      chk(tag, "table conflict", req_conflict, e[0]);
    end

    // R1: timing of a start on a free bus
    clean();
    pulse_start();
    chk("R1", "pending after request", pending, 1'b1);
    chk("R1", "sda not yet low", sda_low, 1'b0);
    tick();
    chk("R1", "sda low", sda_low, 1'b1);
    chk("R1", "scl free during hold", scl_low, 1'b0);
    tick(3);
    chk("R1", "scl free at end of hold", scl_low, 1'b0);
    tick();
    chk("R1", "scl low after hold", scl_low, 1'b1);
    chk("R1", "master after start", is_master, 1'b1);
    chk("R1", "pending cleared", pending, 1'b0);
    chk("R10", "own start marks busy", bus_busy, 1'b1);

    // R5: repeated start from the wait period
    master_wait = 1'b1; pulse_start();
    chk("R5", "restart pending", pending, 1'b1);
    tick(2);
    chk("R5", "held while waiting sda", sda_low, 1'b1);
    chk("R5", "held while waiting scl", scl_low, 1'b1);
    master_wait = 1'b0; tick();
    chk("R5", "release sda", sda_low, 1'b0);
    chk("R5", "scl kept low", scl_low, 1'b1);
    tick(2);
    chk("R5", "scl still low", scl_low, 1'b1);
    tick();
    chk("R5", "both free sda", sda_low, 1'b0);
    chk("R5", "both free scl", scl_low, 1'b0);
    tick(3);
    chk("R5", "restart sda low", sda_low, 1'b1);
    chk("R5", "restart scl free", scl_low, 1'b0);
    tick(4);
    chk("R5", "restart ends scl low", scl_low, 1'b1);
    chk("R5", "still master", is_master, 1'b1);
    chk("R5", "restart pending done", pending, 1'b0);

    // R2: reservation fires when the other master releases the bus
    clean();
    ext_sda = 1'b0; tick(2);
    chk("R10", "busy on sda fall", bus_busy, 1'b1);
    pulse_start(); tick(3);
    chk("R2", "reserved pending", pending, 1'b1);
    chk("R2", "no drive while busy", sda_low, 1'b0);
    ext_sda = 1'b1; tick();
    chk("R10", "free on sda rise", bus_busy, 1'b0);
    chk("R2", "not yet launched", sda_low, 1'b0);
    tick();
    chk("R2", "auto start", sda_low, 1'b1);

    // R6: arbitration loss drops a reservation
    clean();
    ext_sda = 1'b0; tick(2);
    pulse_start();
    arb_lost = 1'b1; tick(); arb_lost = 1'b0;
    chk("R6", "pending after loss", pending, 1'b0);
    ext_sda = 1'b1; tick(3);
    chk("R6", "no start after loss", sda_low, 1'b0);

    // R6/R7: disable drops a reservation
    clean();
    ext_sda = 1'b0; tick(2);
    pulse_start();
    enable = 1'b0; tick();
    chk("R7", "pending after disable", pending, 1'b0);
    chk("R7", "busy after disable", bus_busy, 1'b0);
    enable = 1'b1; ext_sda = 1'b1; tick(2);

    // R4: sticky refusal
    clean();
    resv_off = 1'b1; ext_sda = 1'b0; tick(2);
    pulse_start(); ext_sda = 1'b1; tick(10);
    chk("R4", "rejected stays", start_rejected, 1'b1);
    chk("R3", "no start after refusal", sda_low, 1'b0);
    flag_clr = 1'b1; tick(); flag_clr = 1'b0;
    chk("R4", "rejected cleared", start_rejected, 1'b0);

    // R10: SDA movement with SCL low is not a condition
    clean();
    ext_scl = 1'b0; tick(); ext_sda = 1'b0; tick(2);
    chk("R10", "no busy with scl low", bus_busy, 1'b0);
    ext_sda = 1'b1; tick(); ext_scl = 1'b1; tick(2);
    chk("R10", "still free", bus_busy, 1'b0);

    summary();
  end
endmodule